// File: doc/BRIEF.md
# Bounded Cyclic Ticket Queue Counter

This block numbers the entries of a first-come-first-served queue. It holds two pointers. The issue pointer (`tail`) is the last ticket number handed out. The serve pointer (`head`) is the last ticket number called. Both pointers count upward through an inclusive window set by two limit inputs. When a pointer steps past the upper limit it wraps back to the lower limit. The limits are held constant for the life of the counter, so the capacity is `hi_lim - lo_lim + 1`. Because of the wrap, either pointer may be numerically larger than the other.

Each enabled clock edge performs one operation. With `mode` = 0 the counter issues the next ticket by advancing `tail`, and the new `tail` value is the number given to the newcomer. With `mode` = 1 it calls the next waiting ticket by advancing `head`, and the new `head` value is the number being called. The pointers are equal both when the queue is empty and when it is full. An internal occupancy count, one bit wider than a pointer, tells these two cases apart. The `empty` and `full` flags are decoded from that count. A request that would overflow or underflow the queue is dropped. A synchronous reset restarts the queue with both pointers at the lower limit, so the lower limit counts as already served.

Top module: `tkq_counter`

## Requirements
- R1: On a clock edge with `rst` = 1, `head` and `tail` both load `lo_lim`, `empty` becomes 1 and `full` becomes 0. Reset takes priority over `en` and `mode`.
- R2: Both pointers stay within [`lo_lim`, `hi_lim`] at all times. A pointer that advances while equal to `hi_lim` becomes `lo_lim`.
- R3: With `en` = 1, `mode` = 0 and `full` = 0, an edge advances `tail` by one position, clears `empty` and leaves `head` unchanged.
- R4: With `en` = 1, `mode` = 1 and `empty` = 0, an edge advances `head` by one position, clears `full` and leaves `tail` unchanged.
- R5: `full` is 1 exactly when `hi_lim - lo_lim + 1` tickets are outstanding. At that point `tail` equals `head`. `empty` and `full` are never 1 together. With limits 0..255 the queue holds 256 tickets.
- R6: An issue request (`mode` = 0) while `full` = 1 changes none of `head`, `tail`, `empty` or `full`.
- R7: A serve request (`mode` = 1) while `empty` = 1 changes none of `head`, `tail`, `empty` or `full`.
- R8: With `en` = 0, no output changes on an edge, whatever the value of `mode`.
- R9: When a serve makes `head` equal to `tail`, `empty` becomes 1 and `full` becomes 0.
- R10: With `lo_lim` = `hi_lim` the capacity is one. A single issue sets `full` while `tail` stays at the limit, and a single serve then sets `empty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation enable |
| mode | input | 1 | 0 = issue a ticket, 1 = serve a ticket |
| lo_lim | input | PTR_W | Lowest ticket number (inclusive) |
| hi_lim | input | PTR_W | Highest ticket number (inclusive) |
| head | output | PTR_W | Last ticket number called |
| tail | output | PTR_W | Last ticket number issued |
| empty | output | 1 | No tickets waiting |
| full | output | 1 | Every ticket in the window is outstanding |

## Verification
The bench builds the counter with the default 8-bit pointer width and changes the limit inputs between resets. A 5..10 window exercises wrap of both pointers, blocked issues while full, blocked serves while empty, and disabled edges. A 10..14 window checks that reset follows whatever lower limit is applied. A single-value window reaches the capacity-one case, where every advance wraps onto itself. The full 0..255 window needs a 256-ticket occupancy, which reaches the top bit of the 9-bit count and wraps the issue pointer from 255 to 0.

// File: rtl/tkq_pkg.sv
package tkq_pkg;
    typedef enum logic {
        OP_ISSUE = 1'b0,
        OP_SERVE = 1'b1
    } tkq_op_e;
endpackage

// File: rtl/tkq_wrap_inc.sv
module tkq_wrap_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // A pointer at or above the top of the window returns to its bottom.
    always_comb begin
        if (cur >= hi) nxt = lo;
        else           nxt = cur + ONE;
    end
endmodule

// File: rtl/tkq_flags.sv
module tkq_flags #(
    parameter int W = 8
) (
    input  logic [W:0]   cnt,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         empty,
    output logic         full
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] capacity;

    always_comb begin
        capacity = {1'b0, hi} - {1'b0, lo} + ONE;
        empty    = (cnt == '0);
        full     = (cnt == capacity);
    end
endmodule

// File: rtl/tkq_counter.sv
module tkq_counter
    import tkq_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode,
    input  logic [PTR_W-1:0] lo_lim,
    input  logic [PTR_W-1:0] hi_lim,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             empty,
    output logic             full
);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } tkq_state_t;

    tkq_state_t       st_d, st_q;
    logic [PTR_W-1:0] head_nx, tail_nx;
    logic             empty_w, full_w;
    tkq_op_e          op;

    tkq_wrap_inc #(.W(PTR_W)) u_head_inc (
        .cur(st_q.head), .lo(lo_lim), .hi(hi_lim), .nxt(head_nx)
    );
    tkq_wrap_inc #(.W(PTR_W)) u_tail_inc (
        .cur(st_q.tail), .lo(lo_lim), .hi(hi_lim), .nxt(tail_nx)
    );
    tkq_flags #(.W(PTR_W)) u_flags (
        .cnt(st_q.cnt), .lo(lo_lim), .hi(hi_lim), .empty(empty_w), .full(full_w)
    );

    always_comb begin
        st_d = st_q;
        op   = tkq_op_e'(mode);
        if (rst) begin
            st_d.head = lo_lim;
            st_d.tail = lo_lim;
            st_d.cnt  = '0;
        end else if (en) begin
            case (op)
                OP_ISSUE: if (!full_w) begin
                    st_d.tail = tail_nx;
                    st_d.cnt  = st_q.cnt + CNT_ONE;
                end
                OP_SERVE: if (!empty_w) begin
                    st_d.head = head_nx;
                    st_d.cnt  = st_q.cnt - CNT_ONE;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign empty = empty_w;
    assign full  = full_w;

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (rst)
        (head >= lo_lim) && (head <= hi_lim) && (tail >= lo_lim) && (tail <= hi_lim));

    p_issue_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !mode && !full) |=>
            (tail == (($past(tail) >= hi_lim) ? lo_lim : ($past(tail) + PTR_ONE)))
            && $stable(head) && !empty);

    p_serve_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en && mode && !empty) |=>
            (head == (($past(head) >= hi_lim) ? lo_lim : ($past(head) + PTR_ONE)))
            && $stable(tail) && !full);

    p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !mode && full) |=> $stable(head) && $stable(tail) && full);

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (en && mode && empty) |=> $stable(head) && $stable(tail) && empty);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(head) && $stable(tail) && $stable(empty) && $stable(full));
endmodule

// File: tb/tkq_counter_tb_top.sv
`timescale 1ns/1ps
module tkq_counter_tb_top;
    localparam int W = 8;
    // vector: {en, mode, exp_head, exp_tail, exp_empty, exp_full}
    localparam int VW = 20;
    localparam int NV = 21;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd5,  8'd6,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd5,  8'd7,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd5,  8'd8,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd5,  8'd9,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd5,  8'd10, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd5,  8'd5,  1'b0, 1'b1},
        {1'b1, 1'b0, 8'd5,  8'd5,  1'b0, 1'b1},
        {1'b1, 1'b1, 8'd6,  8'd5,  1'b0, 1'b0},
        {1'b1, 1'b1, 8'd7,  8'd5,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd7,  8'd6,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd7,  8'd7,  1'b0, 1'b1},
        {1'b0, 1'b0, 8'd7,  8'd7,  1'b0, 1'b1},
        {1'b0, 1'b1, 8'd7,  8'd7,  1'b0, 1'b1},
        {1'b1, 1'b1, 8'd8,  8'd7,  1'b0, 1'b0},
        {1'b1, 1'b1, 8'd9,  8'd7,  1'b0, 1'b0},
        {1'b1, 1'b1, 8'd10, 8'd7,  1'b0, 1'b0},
        {1'b1, 1'b1, 8'd5,  8'd7,  1'b0, 1'b0},
        {1'b1, 1'b1, 8'd6,  8'd7,  1'b0, 1'b0},
        {1'b1, 1'b1, 8'd7,  8'd7,  1'b1, 1'b0},
        {1'b1, 1'b1, 8'd7,  8'd7,  1'b1, 1'b0},
        {1'b0, 1'b0, 8'd7,  8'd7,  1'b1, 1'b0}
    };
    localparam string VREQ [NV] = '{
        "R3", "R3", "R3", "R3", "R3", "R5", "R6", "R4", "R4", "R3", "R5",
        "R8", "R8", "R4", "R4", "R2", "R4", "R4", "R9", "R7", "R8"
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] lo_lim = 8'd5;
    logic [W-1:0] hi_lim = 8'd10;
    logic [W-1:0] head, tail;
    logic         empty, full;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tkq_counter #(.PTR_W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .lo_lim(lo_lim), .hi_lim(hi_lim),
        .head(head), .tail(tail), .empty(empty), .full(full)
    );

    task automatic check(input string req, input logic [W-1:0] eh, input logic [W-1:0] et,
                         input logic ee, input logic ef);
        n_cmp++;
        if (head !== eh || tail !== et || empty !== ee || full !== ef) begin
            n_bad++;
            $display("FAIL %s: got head=%0d tail=%0d empty=%0b full=%0b, expected head=%0d tail=%0d empty=%0b full=%0b",
                     req, head, tail, empty, full, eh, et, ee, ef);
        end
    endtask

    // Inputs change at a falling edge; the following falling edge sees the registered result.
    task automatic step(input logic r, input logic e, input logic m);
        rst  = r;
        en   = e;
        mode = m;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0);
        check("R1", 8'd5, 8'd5, 1'b1, 1'b0);
        for (int i = 0; i < NV; i++) begin
            step(1'b0, VEC[i][19], VEC[i][18]);
            check(VREQ[i], VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset wins over a pending issue
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        check("R1", 8'd5, 8'd5, 1'b1, 1'b0);

        // R1: reset follows a new lower limit (window 10..14)
        lo_lim = 8'd10; hi_lim = 8'd14;
        step(1'b1, 1'b0, 1'b0);
        check("R1", 8'd10, 8'd10, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check("R3", 8'd10, 8'd11, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check("R9", 8'd11, 8'd11, 1'b1, 1'b0);

        // R10: single-ticket window 3..3
        lo_lim = 8'd3; hi_lim = 8'd3;
        step(1'b1, 1'b0, 1'b0);
        check("R1", 8'd3, 8'd3, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check("R10", 8'd3, 8'd3, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        check("R6", 8'd3, 8'd3, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        check("R10", 8'd3, 8'd3, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        check("R7", 8'd3, 8'd3, 1'b1, 1'b0);

        // R5: full window 0..255 holds 256 tickets
        lo_lim = 8'd0; hi_lim = 8'd255;
        step(1'b1, 1'b0, 1'b0);
        check("R1", 8'd0, 8'd0, 1'b1, 1'b0);
        for (int k = 0; k < 255; k++) step(1'b0, 1'b1, 1'b0);
        check("R5", 8'd0, 8'd255, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        check("R5", 8'd0, 8'd0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        check("R6", 8'd0, 8'd0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        check("R4", 8'd1, 8'd0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        check("R8", 8'd1, 8'd0, 1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got no completion, expected completion within 5000 cycles");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule